// File: doc/BRIEF.md
# Pop-Free Audio Front-End Power and Mode Sequencer

This block is the host-side controller for an analog audio front end that is configured over a three-wire serial port (chip select, clock, data). It brings the front end out of standby and moves it between record, speaker playback and line playback. It never writes a single register to do this. Each transition is an ordered series of 16-bit control words with a minimum delay between them, so the analog sections power up and switch without audible clicks.

A one-cycle start request carries a target mode and a 5-bit volume code. On the first request after reset, the block raises the standby line and waits. It then sends a chip-select pulse with no clock, followed by the power-up words for the target. Later requests choose a switching series from the current mode to the target. A busy flag covers each series. All delays come from a parameter table in milliseconds, counted by a restartable millisecond timebase. The serial master stretches every clock phase and every chip-select setup and hold interval to a programmable number of system clocks.

Top module: `popfree_seq`

## Requirements
- R1: While reset is applied, and in the first cycles after it, fe_standby, fe_cs, fe_sclk, fe_sdata and busy are all 0.
- R2: A control word is framed by fe_cs high. It carries 16 bits, bit 0 first, each valid at a rising fe_sclk edge, and fe_sclk is high only inside a frame. The bit fields are:
  - bit 1: corner select
  - bit 2: charge-circuit disable
  - bit 3: mic disable
  - bit 4: ALC disable
  - bit 5: record filter
  - bit 6: alternate playback filter
  - bit 7: record block disable
  - bit 8: line disable
  - bit 9: line unmute
  - bit 10: speaker disable
  - bits 15:11: volume
  - bit 0: always 0
- R3: The following intervals each last at least HALF_DIV clocks (84 by default, at least 333 ns at 250 MHz): every fe_sclk high phase, every fe_sclk low phase, fe_cs rise to the first fe_sclk rise, and the last fe_sclk fall to fe_cs fall.
- R4: The first accepted start after reset raises fe_standby, and fe_standby then stays high until reset. After 200 ms, a dummy frame follows (fe_cs high with no fe_sclk edge). Control words come only after the dummy frame, and fe_cs never rises while fe_standby is low.
- R5: The power-up for a playback target (mode 1 or 2) sends four words. Each word waits at least the stated time after the previous transaction:
  - 0x059C, 20 ms after the dummy frame
  - 0x019C, after 50 ms
  - 0x029C, after 150 ms
  - 0x0502, after 10 ms
- R6: The power-up for a record target (mode 0) sends three words, each after the stated wait:
  - 0x0534, 20 ms after the dummy frame
  - 0x0524, after 30 ms
  - 0x0502, after 10 ms
- R7: Entering speaker playback from record or line playback sends three words:
  - 0x0524
  - 0x059C with the volume in bits 15:11
  - the same word with bit 10 cleared, at least 20 ms later
- R8: Leaving speaker playback for record sends 0x0524, then 0x0124 at least 20 ms later.
- R9: Entering line playback from record or speaker playback sends 0x059C, then 0x029C at least 5 ms later. Leaving line playback for record sends the single word 0x0524.
- R10: busy rises in the cycle after an accepted start. It stays high through every frame of the series and falls only after the last frame's fe_cs has dropped. A start that arrives while busy is high is ignored and is not queued.
- R11: A start is ignored, with no frame sent and busy staying low, in two cases: the mode code is 3, or the target equals the current mode after a series has completed.
- R12: A nonzero programmed wait of N ms puts at least N*TICK_DIV clocks, and at most HALF_DIV+8 clocks more, between one transaction's fe_cs fall and the next fe_cs rise.
- R13: The volume code is captured with the start request. Changes on vol during the series do not alter the words that are sent.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| start | input | 1 | One-cycle request to run a power-up or switching series |
| mode | input | 2 | Target: 0 record, 1 speaker playback, 2 line playback, 3 reserved |
| vol | input | 5 | Volume code used in speaker playback words |
| fe_standby | output | 1 | Standby release line to the front end (1 = active) |
| fe_cs | output | 1 | Serial chip select, high during a frame |
| fe_sclk | output | 1 | Serial clock |
| fe_sdata | output | 1 | Serial data, bit 0 first |
| busy | output | 1 | High while a series is in progress |

## Verification
Two of the block's functions can fall in the same cycle. First, a new start request can meet an ongoing series. The bench provokes this by pulsing start with a different target and a new volume in the middle of a speaker-entry series. It then judges that the decoded word list, the volume field and the later behaviour match only the first request. Second, the restart of the millisecond timebase can coincide with the end of a frame. Every gap between frames is measured against both a lower and an upper bound, so a timebase that is not restarted, or a wait that loses or gains a tick, shows up as a gap outside the window.

// File: rtl/popfree_pkg.sv
package popfree_pkg;

  localparam int WORD_W = 16;
  localparam int VOL_W  = 5;

  // Field positions decoded by the front end.
  localparam int B_CORNER  = 1;
  localparam int B_CHG_OFF = 2;
  localparam int B_MIC_OFF = 3;
  localparam int B_ALC_OFF = 4;
  localparam int B_REC_FLT = 5;
  localparam int B_ALT_FLT = 6;
  localparam int B_REC_OFF = 7;
  localparam int B_LIN_OFF = 8;
  localparam int B_LIN_UNM = 9;
  localparam int B_SPK_OFF = 10;
  localparam int B_VOL_LO  = 11;

  typedef enum logic [1:0] {
    MODE_REC  = 2'd0,
    MODE_SPK  = 2'd1,
    MODE_LINE = 2'd2,
    MODE_RSVD = 2'd3
  } fe_mode_e;

  typedef enum logic [2:0] {
    SQ_NONE      = 3'd0,
    SQ_UP_PB     = 3'd1,
    SQ_UP_REC    = 3'd2,
    SQ_TO_SPK    = 3'd3,
    SQ_SPK_2_REC = 3'd4,
    SQ_LIN_2_REC = 3'd5,
    SQ_TO_LINE   = 3'd6
  } seq_id_e;

  typedef enum logic [1:0] {
    ACT_STBY  = 2'd0,
    ACT_DUMMY = 2'd1,
    ACT_WORD  = 2'd2
  } act_e;

  function automatic logic [WORD_W-1:0] fe_word(
    input logic corner, input logic alt_flt, input logic chg_off,
    input logic mic_off, input logic alc_off, input logic rec_flt,
    input logic rec_off, input logic lin_off, input logic lin_unm,
    input logic spk_off, input logic [VOL_W-1:0] volc);
    logic [WORD_W-1:0] w;
    w = '0;
    w[B_CORNER]  = corner;
    w[B_CHG_OFF] = chg_off;
    w[B_MIC_OFF] = mic_off;
    w[B_ALC_OFF] = alc_off;
    w[B_REC_FLT] = rec_flt;
    w[B_ALT_FLT] = alt_flt;
    w[B_REC_OFF] = rec_off;
    w[B_LIN_OFF] = lin_off;
    w[B_LIN_UNM] = lin_unm;
    w[B_SPK_OFF] = spk_off;
    w[B_VOL_LO +: VOL_W] = volc;
    return w;
  endfunction

endpackage

// File: rtl/ms_timebase.sv
module ms_timebase #(
  parameter int TICK_DIV = 250000
) (
  input  logic clk,
  input  logic rst_ni,
  input  logic clr,
  output logic tick
);
  localparam int TW = $clog2(TICK_DIV + 1);
  localparam logic [TW-1:0] LAST = TW'(TICK_DIV - 1);

  logic [TW-1:0] cnt_q, cnt_n;
  logic          tick_n;

  always_comb begin
    tick_n = 1'b0;
    if (clr) begin
      cnt_n = '0;
    end else if (cnt_q == LAST) begin
      cnt_n  = '0;
      tick_n = 1'b1;
    end else begin
      cnt_n = cnt_q + TW'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      tick  <= 1'b0;
    end else begin
      cnt_q <= cnt_n;
      tick  <= tick_n;
    end
  end
endmodule

// File: rtl/tw_master.sv
module tw_master #(
  parameter int WORD_W   = 16,
  parameter int HALF_DIV = 84
) (
  input  logic              clk,
  input  logic              rst_ni,
  input  logic              go,
  input  logic              dummy,
  input  logic [WORD_W-1:0] word,
  output logic              cs,
  output logic              sclk,
  output logic              sdata,
  output logic              done
);
  localparam int PW = $clog2(HALF_DIV + 1);
  localparam int BW = $clog2(WORD_W);
  localparam logic [PW-1:0] PLAST = PW'(HALF_DIV - 1);
  localparam logic [BW-1:0] BLAST = BW'(WORD_W - 1);

  typedef enum logic [2:0] {M_IDLE, M_SETUP, M_HI, M_LO, M_HOLD, M_GAP} mst_e;

  mst_e              st_q, st_n;
  logic [PW-1:0]     pcnt_q, pcnt_n;
  logic [BW-1:0]     bit_q, bit_n;
  logic [WORD_W-1:0] sh_q, sh_n;
  logic              dmy_q, dmy_n, done_n;
  logic              ph_end;

  assign ph_end = (pcnt_q == PLAST);

  always_comb begin
    st_n   = st_q;
    bit_n  = bit_q;
    sh_n   = sh_q;
    dmy_n  = dmy_q;
    done_n = 1'b0;
    pcnt_n = ph_end ? '0 : pcnt_q + PW'(1);
    case (st_q)
      M_IDLE: begin
        pcnt_n = '0;
        if (go) begin
          st_n  = M_SETUP;
          bit_n = '0;
          dmy_n = dummy;
          sh_n  = dummy ? '0 : word;
        end
      end
      M_SETUP: if (ph_end) st_n = dmy_q ? M_HOLD : M_HI;
      M_HI: if (ph_end) begin
        if (bit_q == BLAST) begin
          st_n = M_HOLD;
        end else begin
          st_n  = M_LO;
          sh_n  = sh_q >> 1;
          bit_n = bit_q + BW'(1);
        end
      end
      M_LO:   if (ph_end) st_n = M_HI;
      M_HOLD: if (ph_end) st_n = M_GAP;
      M_GAP: if (ph_end) begin
        st_n   = M_IDLE;
        done_n = 1'b1;
      end
      default: st_n = M_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= M_IDLE;
      pcnt_q <= '0;
      bit_q  <= '0;
      sh_q   <= '0;
      dmy_q  <= 1'b0;
      done   <= 1'b0;
      cs     <= 1'b0;
      sclk   <= 1'b0;
      sdata  <= 1'b0;
    end else begin
      st_q   <= st_n;
      pcnt_q <= pcnt_n;
      bit_q  <= bit_n;
      sh_q   <= sh_n;
      dmy_q  <= dmy_n;
      done   <= done_n;
      cs     <= (st_n == M_SETUP) || (st_n == M_HI) || (st_n == M_LO) || (st_n == M_HOLD);
      sclk   <= (st_n == M_HI);
      sdata  <= (st_n == M_IDLE || st_n == M_GAP) ? 1'b0 : sh_n[0];
    end
  end
endmodule

// File: rtl/seq_rom.sv
module seq_rom
  import popfree_pkg::*;
#(
  parameter int   DLY_W       = 8,
  parameter logic CORNER_SEL  = 1'b0,
  parameter logic PB_ALT_FLT  = 1'b0,
  parameter int   D_STBY      = 200,
  parameter int   D_DUMMY     = 20,
  parameter int   D_CHG       = 50,
  parameter int   D_SPK_UP    = 150,
  parameter int   D_LINE_UP   = 10,
  parameter int   D_ALC       = 30,
  parameter int   D_REC_UP    = 10,
  parameter int   D_SPK_SW    = 20,
  parameter int   D_LINE_SW   = 5
) (
  input  seq_id_e           seq,
  input  logic [2:0]        idx,
  input  logic [VOL_W-1:0]  volc,
  output act_e              act,
  output logic [WORD_W-1:0] word,
  output logic [DLY_W-1:0]  wait_ms,
  output logic              last
);
  localparam logic [VOL_W-1:0] V0 = '0;
  logic [WORD_W-1:0] w_dflt, w_pb_idle, w_pb_spk, w_pb_line;
  logic [WORD_W-1:0] w_rec_up, w_rec_mute, w_rec_spk, w_sw_idle, w_sw_spk;

  always_comb begin
    w_dflt     = fe_word(1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b1, V0);
    w_pb_idle  = fe_word(CORNER_SEL, PB_ALT_FLT, 1'b1, 1'b1, 1'b1, 1'b0, 1'b1, 1'b1, 1'b0, 1'b1, V0);
    w_pb_spk   = fe_word(CORNER_SEL, PB_ALT_FLT, 1'b1, 1'b1, 1'b1, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0, V0);
    w_pb_line  = fe_word(CORNER_SEL, PB_ALT_FLT, 1'b1, 1'b1, 1'b1, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0, V0);
    w_rec_up   = fe_word(CORNER_SEL, 1'b0, 1'b1, 1'b0, 1'b1, 1'b1, 1'b0, 1'b1, 1'b0, 1'b1, V0);
    w_rec_mute = fe_word(CORNER_SEL, 1'b0, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 1'b1, V0);
    w_rec_spk  = fe_word(CORNER_SEL, 1'b0, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0, V0);
    w_sw_idle  = fe_word(CORNER_SEL, PB_ALT_FLT, 1'b1, 1'b1, 1'b1, 1'b0, 1'b1, 1'b1, 1'b0, 1'b1, volc);
    w_sw_spk   = fe_word(CORNER_SEL, PB_ALT_FLT, 1'b1, 1'b1, 1'b1, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0, volc);
  end

  always_comb begin
    act     = ACT_WORD;
    word    = w_dflt;
    wait_ms = '0;
    last    = 1'b0;
    case (seq)
      SQ_UP_PB, SQ_UP_REC: begin
        case (idx)
          3'd0: begin act = ACT_STBY;  wait_ms = DLY_W'(D_STBY);  end
          3'd1: begin act = ACT_DUMMY; wait_ms = DLY_W'(D_DUMMY); end
          3'd2: begin
            word    = (seq == SQ_UP_PB) ? w_pb_idle : w_rec_up;
            wait_ms = (seq == SQ_UP_PB) ? DLY_W'(D_CHG) : DLY_W'(D_ALC);
          end
          3'd3: begin
            word    = (seq == SQ_UP_PB) ? w_pb_spk : w_rec_mute;
            wait_ms = (seq == SQ_UP_PB) ? DLY_W'(D_SPK_UP) : DLY_W'(D_REC_UP);
            last    = (seq == SQ_UP_REC) ? 1'b0 : 1'b0;
          end
          3'd4: begin
            word    = (seq == SQ_UP_PB) ? w_pb_line : w_dflt;
            wait_ms = (seq == SQ_UP_PB) ? DLY_W'(D_LINE_UP) : '0;
            last    = (seq == SQ_UP_REC);
          end
          default: begin word = w_dflt; last = 1'b1; end
        endcase
      end
      SQ_TO_SPK: begin
        case (idx)
          3'd0:    word = w_rec_mute;
          3'd1:    begin word = w_sw_idle; wait_ms = DLY_W'(D_SPK_SW); end
          default: begin word = w_sw_spk; last = 1'b1; end
        endcase
      end
      SQ_SPK_2_REC: begin
        if (idx == 3'd0) begin word = w_rec_mute; wait_ms = DLY_W'(D_SPK_SW); end
        else             begin word = w_rec_spk;  last = 1'b1; end
      end
      SQ_LIN_2_REC: begin word = w_rec_mute; last = 1'b1; end
      SQ_TO_LINE: begin
        if (idx == 3'd0) begin word = w_pb_idle; wait_ms = DLY_W'(D_LINE_SW); end
        else             begin word = w_pb_line; last = 1'b1; end
      end
      default: begin act = ACT_STBY; last = 1'b1; end
    endcase
  end
endmodule

// File: rtl/popfree_seq.sv
module popfree_seq
  import popfree_pkg::*;
#(
  parameter int   TICK_DIV   = 250000,
  parameter int   HALF_DIV   = 84,
  parameter int   DLY_W      = 8,
  parameter logic CORNER_SEL = 1'b0,
  parameter logic PB_ALT_FLT = 1'b0,
  parameter int   D_STBY     = 200,
  parameter int   D_DUMMY    = 20,
  parameter int   D_CHG      = 50,
  parameter int   D_SPK_UP   = 150,
  parameter int   D_LINE_UP  = 10,
  parameter int   D_ALC      = 30,
  parameter int   D_REC_UP   = 10,
  parameter int   D_SPK_SW   = 20,
  parameter int   D_LINE_SW  = 5
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start,
  input  logic [1:0] mode,
  input  logic [4:0] vol,
  output logic       fe_standby,
  output logic       fe_cs,
  output logic       fe_sclk,
  output logic       fe_sdata,
  output logic       busy
);
  typedef enum logic [1:0] {Q_IDLE, Q_ACT, Q_XFER, Q_WAIT} qst_e;

  logic [1:0] rsync_q;
  logic       rst_ni;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rsync_q <= 2'b00;
    else        rsync_q <= {rsync_q[0], 1'b1};
  end
  assign rst_ni = rsync_q[1];

  qst_e             st_q, st_n;
  seq_id_e          seq_q, seq_n, sel;
  fe_mode_e         cur_q, cur_n, tgt_q, tgt_n, req;
  logic [2:0]       idx_q, idx_n;
  logic [VOL_W-1:0] vol_q, vol_n;
  logic [DLY_W-1:0] dly_q, dly_n;
  logic             pwr_q, pwr_n, stby_n, busy_n, step_done, tb_clr, m_go;
  logic             tick, m_done;
  act_e             r_act;
  logic [WORD_W-1:0] r_word;
  logic [DLY_W-1:0]  r_wait;
  logic              r_last;

  assign req = fe_mode_e'(mode);

  always_comb begin
    sel = SQ_NONE;
    if (req != MODE_RSVD) begin
      if (!pwr_q)                sel = (req == MODE_REC) ? SQ_UP_REC : SQ_UP_PB;
      else if (req == cur_q)     sel = SQ_NONE;
      else if (req == MODE_REC)  sel = (cur_q == MODE_SPK) ? SQ_SPK_2_REC : SQ_LIN_2_REC;
      else if (req == MODE_SPK)  sel = SQ_TO_SPK;
      else                       sel = SQ_TO_LINE;
    end
  end

  always_comb begin
    st_n = st_q; seq_n = seq_q; cur_n = cur_q; tgt_n = tgt_q;
    idx_n = idx_q; vol_n = vol_q; dly_n = dly_q; pwr_n = pwr_q;
    stby_n = fe_standby; busy_n = busy;
    step_done = 1'b0; tb_clr = 1'b0; m_go = 1'b0;
    case (st_q)
      Q_IDLE: if (start && sel != SQ_NONE) begin
        st_n = Q_ACT; seq_n = sel; idx_n = '0;
        vol_n = vol; tgt_n = req; busy_n = 1'b1;
      end
      Q_ACT: begin
        if (r_act == ACT_STBY) begin
          stby_n    = 1'b1;
          step_done = 1'b1;
        end else begin
          m_go = 1'b1;
          st_n = Q_XFER;
        end
      end
      Q_XFER: step_done = m_done;
      Q_WAIT: if (tick) begin
        if (dly_q == DLY_W'(1)) begin
          st_n  = Q_ACT;
          idx_n = idx_q + 3'd1;
        end else begin
          dly_n = dly_q - DLY_W'(1);
        end
      end
      default: st_n = Q_IDLE;
    endcase
    if (step_done) begin
      if (r_last) begin
        st_n = Q_IDLE; busy_n = 1'b0; pwr_n = 1'b1; cur_n = tgt_q;
      end else if (r_wait == '0) begin
        st_n = Q_ACT; idx_n = idx_q + 3'd1;
      end else begin
        st_n = Q_WAIT; dly_n = r_wait; tb_clr = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q       <= Q_IDLE;
      seq_q      <= SQ_NONE;
      cur_q      <= MODE_REC;
      tgt_q      <= MODE_REC;
      idx_q      <= '0;
      vol_q      <= '0;
      dly_q      <= '0;
      pwr_q      <= 1'b0;
      fe_standby <= 1'b0;
      busy       <= 1'b0;
    end else begin
      st_q       <= st_n;
      seq_q      <= seq_n;
      cur_q      <= cur_n;
      tgt_q      <= tgt_n;
      idx_q      <= idx_n;
      vol_q      <= vol_n;
      dly_q      <= dly_n;
      pwr_q      <= pwr_n;
      fe_standby <= stby_n;
      busy       <= busy_n;
    end
  end

  seq_rom #(
    .DLY_W(DLY_W), .CORNER_SEL(CORNER_SEL), .PB_ALT_FLT(PB_ALT_FLT),
    .D_STBY(D_STBY), .D_DUMMY(D_DUMMY), .D_CHG(D_CHG), .D_SPK_UP(D_SPK_UP),
    .D_LINE_UP(D_LINE_UP), .D_ALC(D_ALC), .D_REC_UP(D_REC_UP),
    .D_SPK_SW(D_SPK_SW), .D_LINE_SW(D_LINE_SW)
  ) u_rom (
    .seq(seq_q), .idx(idx_q), .volc(vol_q),
    .act(r_act), .word(r_word), .wait_ms(r_wait), .last(r_last)
  );

  ms_timebase #(.TICK_DIV(TICK_DIV)) u_tb (
    .clk(clk), .rst_ni(rst_ni), .clr(tb_clr), .tick(tick)
  );

  tw_master #(.WORD_W(WORD_W), .HALF_DIV(HALF_DIV)) u_ser (
    .clk(clk), .rst_ni(rst_ni), .go(m_go), .dummy(r_act == ACT_DUMMY),
    .word(r_word), .cs(fe_cs), .sclk(fe_sclk), .sdata(fe_sdata), .done(m_done)
  );
endmodule

// File: rtl/popfree_seq_chk.sv
module popfree_seq_chk #(
  parameter int HALF_DIV = 84
) (
  input logic clk,
  input logic rst_n,
  input logic fe_standby,
  input logic fe_cs,
  input logic fe_sclk,
  input logic busy
);
  logic [15:0] held_q;
  logic        prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      held_q <= 16'hFFFF;
      prev_q <= 1'b0;
    end else begin
      prev_q <= fe_sclk;
      if (fe_sclk != prev_q)     held_q <= 16'd1;
      else if (held_q != 16'hFFFF) held_q <= held_q + 16'd1;
    end
  end

  // R2
  sclk_in_frame_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fe_sclk |-> fe_cs);

  // R3
  sclk_phase_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fe_sclk != prev_q) |-> (held_q >= 16'(HALF_DIV)));

  // R4
  cs_needs_standby_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fe_cs |-> fe_standby);

  // R4
  standby_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fe_standby |=> fe_standby);

  // R10
  quiet_when_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (!fe_cs && !fe_sclk));

  // R10
  busy_drop_clean_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> !fe_cs);
endmodule

bind popfree_seq popfree_seq_chk #(.HALF_DIV(HALF_DIV)) u_chk (
  .clk(clk), .rst_n(rst_n), .fe_standby(fe_standby),
  .fe_cs(fe_cs), .fe_sclk(fe_sclk), .busy(busy)
);

// File: tb/popfree_seq_tb.sv
`timescale 1ns/1ps
module popfree_seq_tb;
  localparam int T = 20;
  localparam int H = 84;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic [1:0] mode = 2'd0;
  logic [4:0] vol = 5'd0;
  logic fe_standby, fe_cs, fe_sclk, fe_sdata, busy;

  always #2 clk = ~clk;

  popfree_seq #(.TICK_DIV(T), .HALF_DIV(H)) u_dut (
    .clk(clk), .rst_n(rst_n), .start(start), .mode(mode), .vol(vol),
    .fe_standby(fe_standby), .fe_cs(fe_cs), .fe_sclk(fe_sclk),
    .fe_sdata(fe_sdata), .busy(busy)
  );

  int nchk = 0, nerr = 0;
  int cyc = 0, n_tx = 0, stby_rise = 0, last_evt = 0, min_ph = 1000000;
  int bits_c = 0;
  logic [15:0] sh_c;
  logic p_cs = 0, p_sclk = 0, p_stby = 0;
  logic [15:0] tx_word [0:63];
  int tx_bits [0:63];
  int tx_rise [0:63];
  int tx_fall [0:63];
  logic tx_busy [0:63];
  int cur_rise = 0;
  logic [15:0] ew [0:7];
  int eb [0:7];
  int eg [0:7];

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    nchk++;
    if (!ok) begin
      nerr++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
    end
  endtask

  always @(negedge clk) begin
    cyc++;
    if (cyc > 190000) begin
      nerr++;
      $display("FAIL R10 watchdog: actual %0d expected < 190000 cycles", cyc);
      $display("CHECKS %0d ERRORS %0d", nchk, nerr);
      $finish;
    end
    if (fe_standby && !p_stby) stby_rise = cyc;
    if (fe_cs && !p_cs) begin
      cur_rise = cyc; bits_c = 0; sh_c = '0; last_evt = cyc;
    end else if (fe_cs && p_cs && fe_sclk != p_sclk) begin
      if (cyc - last_evt < min_ph) min_ph = cyc - last_evt;
      last_evt = cyc;
      if (fe_sclk) begin
        if (bits_c < 16) sh_c[bits_c] = fe_sdata;
        bits_c++;
      end
    end
    if (!fe_cs && p_cs) begin
      if (cyc - last_evt < min_ph) min_ph = cyc - last_evt;
      if (n_tx < 64) begin
        tx_word[n_tx] = sh_c; tx_bits[n_tx] = bits_c;
        tx_rise[n_tx] = cur_rise; tx_fall[n_tx] = cyc; tx_busy[n_tx] = busy;
        n_tx++;
      end
    end
    p_cs = fe_cs; p_sclk = fe_sclk; p_stby = fe_standby;
  end

  task automatic set_exp(input int i, input int b, input logic [15:0] w, input int g);
    eb[i] = b; ew[i] = w; eg[i] = g;
  endtask

  task automatic do_start(input logic [1:0] m, input logic [4:0] v);
    @(negedge clk); start = 1'b1; mode = m; vol = v;
    @(negedge clk); start = 1'b0;
  endtask

  task automatic wait_idle();
    while (busy) @(negedge clk);
  endtask

  task automatic verify(input string req, input int base, input int n);
    check(n_tx - base == n, req, "frame count", n_tx - base, n);
    for (int i = 0; i < n && base + i < n_tx; i++) begin
      check(tx_bits[base+i] == eb[i], req, "clock edges in frame", tx_bits[base+i], eb[i]);
      if (eb[i] == 16) check(tx_word[base+i] == ew[i], req, "word", tx_word[base+i], ew[i]);
      check(tx_busy[base+i] == 1'b1, "R10", "busy during frame", tx_busy[base+i], 1);
      if (i > 0) begin
        int gap = tx_rise[base+i] - tx_fall[base+i-1];
        check(gap >= eg[i]*T && gap <= eg[i]*T + H + 8, "R12", "gap cycles", gap, eg[i]*T);
      end
    end
  endtask

  task automatic t_reset();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    check({fe_standby, fe_cs, fe_sclk, fe_sdata, busy} == 5'b0, "R1", "outputs in reset",
          {fe_standby, fe_cs, fe_sclk, fe_sdata, busy}, 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check({fe_standby, fe_cs, fe_sclk, fe_sdata, busy} == 5'b0, "R1", "outputs after reset",
          {fe_standby, fe_cs, fe_sclk, fe_sdata, busy}, 0);
  endtask

  task automatic t_powerup_pb();
    int base = n_tx;
    do_start(2'd1, 5'd17);
    check(busy == 1'b1, "R10", "busy after start", busy, 1);
    wait_idle();
    set_exp(0, 0, 16'h0, 0);
    set_exp(1, 16, 16'h059C, 20);
    set_exp(2, 16, 16'h019C, 50);
    set_exp(3, 16, 16'h029C, 150);
    set_exp(4, 16, 16'h0502, 10);
    verify("R5", base, 5);
    check(tx_rise[base] - stby_rise >= 200*T && tx_rise[base] - stby_rise <= 200*T + 8,
          "R4", "standby to dummy cycles", tx_rise[base] - stby_rise, 200*T);
    check(fe_standby == 1'b1, "R4", "standby held", fe_standby, 1);
  endtask

  task automatic t_ignored();
    int base = n_tx;
    do_start(2'd1, 5'd3);
    check(busy == 1'b0, "R11", "busy on same-mode start", busy, 0);
    do_start(2'd3, 5'd3);
    check(busy == 1'b0, "R11", "busy on reserved mode", busy, 0);
    repeat (400) @(negedge clk);
    check(n_tx == base, "R11", "frames after ignored starts", n_tx - base, 0);
  endtask

  task automatic t_spk_to_rec();
    int base = n_tx;
    do_start(2'd0, 5'd9);
    wait_idle();
    set_exp(0, 16, 16'h0524, 0);
    set_exp(1, 16, 16'h0124, 20);
    verify("R8", base, 2);
  endtask

  task automatic t_rec_to_line();
    int base = n_tx;
    do_start(2'd2, 5'd4);
    wait_idle();
    set_exp(0, 16, 16'h059C, 0);
    set_exp(1, 16, 16'h029C, 5);
    verify("R9", base, 2);
  endtask

  task automatic t_line_to_rec();
    int base = n_tx;
    do_start(2'd0, 5'd4);
    wait_idle();
    set_exp(0, 16, 16'h0524, 0);
    verify("R9", base, 1);
  endtask

  task automatic t_rec_to_spk_latched();
    int base = n_tx;
    do_start(2'd1, 5'd31);
    vol = 5'd0;
    repeat (300) @(negedge clk);
    start = 1'b1; mode = 2'd2; vol = 5'd5;
    @(negedge clk); start = 1'b0;
    wait_idle();
    set_exp(0, 16, 16'h0524, 0);
    set_exp(1, 16, 16'hFD9C, 0);
    set_exp(2, 16, 16'hF99C, 20);
    verify("R7", base, 3);
    check(tx_word[base+2][15:11] == 5'd31, "R13", "volume field", tx_word[base+2][15:11], 31);
    repeat (400) @(negedge clk);
    check(n_tx == base + 3, "R10", "start during busy not queued", n_tx - base, 3);
  endtask

  task automatic t_spk_to_line();
    int base = n_tx;
    do_start(2'd2, 5'd0);
    wait_idle();
    set_exp(0, 16, 16'h059C, 0);
    set_exp(1, 16, 16'h029C, 5);
    verify("R9", base, 2);
  endtask

  task automatic t_powerup_rec();
    int base;
    t_reset();
    base = n_tx;
    do_start(2'd0, 5'd12);
    wait_idle();
    set_exp(0, 0, 16'h0, 0);
    set_exp(1, 16, 16'h0534, 20);
    set_exp(2, 16, 16'h0524, 30);
    set_exp(3, 16, 16'h0502, 10);
    verify("R6", base, 4);
    check(tx_rise[base] > stby_rise, "R4", "dummy after standby", tx_rise[base], stby_rise);
  endtask

  initial begin
    t_reset();
    t_powerup_pb();
    t_ignored();
    t_spk_to_rec();
    t_rec_to_line();
    t_line_to_rec();
    t_rec_to_spk_latched();
    t_spk_to_line();
    t_powerup_rec();
    check(min_ph >= H, "R3", "shortest phase cycles", min_ph, H);
    check(n_tx > 0 && tx_bits[1] == 16, "R2", "frame bit count", tx_bits[1], 16);
    $display("CHECKS %0d ERRORS %0d", nchk, nerr);
    $finish;
  end
endmodule